// File: doc/BRIEF.md
# Input Channel Word Packer

This block sits on one input I/O channel and turns a stream of device characters into 24-bit memory words. Characters arrive over a valid/ready handshake and may be 6, 12 or 24 bits wide. Each new character is shifted in at the low end of an assembly register, so a finished word holds the first character at its most significant end. A programmable count decides how many characters make one word. When a word is complete and memory interlace is enabled, the block issues a one-cycle memory write strobe that carries the address and data. It then waits for the acknowledge, steps the address up, and steps the 15-bit word count down.

A connect pulse loads the channel setup. The setup holds the character width, the characters-per-word field, the transfer function, the interlace, scan and interrupt-enable bits, and the start address and word count. The transfer function chooses what happens at the edges of a transfer:

- what happens when the word count runs out;
- what happens when a word completes with interlace off;
- whether an end of record leaves the channel connected between records or disconnects it.

A partial word present at end of record is left-justified before it is stored.

Back-pressure rules: `ch_ready` is high only while the channel is connected, is not between records, has no memory store outstanding, and has no end of record waiting to be processed. A character transfers on a rising edge where `ch_valid` and `ch_ready` are both high. `ch_data` and `ch_err` are sampled on that edge only. After `mem_req` pulses, `ch_ready` stays low until `mem_ack` is seen. `mem_ack` may come in the same cycle as `mem_req` or in any later cycle.

Top module: `chan_word_packer`

## Requirements
- R1: After reset the channel is disconnected. `ch_ready`, `mem_req`, `inter_rec`, `err_flag`, `word_full` and all interrupt and `disc` pulses are low.
- R2: `start` loads the setup and connects the channel only while `connected` is low. A `start` that arrives while connected has no effect: `mem_addr` and `word_count` keep their values.
- R3: Width code 00 selects 6-bit characters. Each character does word = (word << 6) | char[5:0], kept to 24 bits. The word is full after `cfg_cpw`+1 characters, and `word_full` shows the full state.
- R4: Width code 01 selects 12-bit characters and uses only bit 0 of `cfg_cpw` (1 or 2 per word), with a shift of 12. Width codes 1x select 24-bit characters: one character per word, replacing the register.
- R5: With interlace on, a full word produces a `mem_req` pulse exactly one cycle long, carrying `mem_addr` and `mem_data`. Once `mem_ack` arrives, the address increments, `word_count` decrements modulo 2^15 (0 becomes 0x7FFF), and the register clears.
- R6: When a store brings `word_count` to zero, interlace turns off. For any function with bit 2 set, `irq_zwc` pulses if the zero-count enable is set. Function 110 also pulses `irq_eor` (if its enable is set) and then disconnects with a `disc` pulse.
- R7: With interlace off, a full word has one of three outcomes by function. In compatible mode (bit 2 clear), `irq_eow` pulses when `cpu_int_en` is high. In the signal functions (bits 2:1 = 11), `err_flag` sets. In the record functions (bits 2:1 = 10), the counter drops back to one below full, so the next character shifts in without `word_full` or an error.
- R8: At end of record, a partial word is left-justified. In 6-bit mode the shift is 6 per missing character. In 12-bit mode the shift is 12 if any character is missing. In 24-bit mode the word becomes zero. For functions other than compatible mode, a partial word that holds at least one character is then stored if interlace is on. In compatible mode the word is padded but not stored.
- R9: Finishing an end of record does the following:
  - It turns interlace off.
  - It pulses `irq_eor` if the end-of-record enable is set, or if in compatible mode with `cpu_int_en` high.
  - For proceed functions (bits 2 and 0 set) it enters the inter-record state: `inter_rec` goes high, `connected` stays high and `ch_ready` stays low.
  - For any other function it disconnects with a `disc` pulse.
- R10: In scan mode the counter is held at the characters-per-word value, so no word is ever full and no store is made.
- R11: A character accepted with `ch_err` high sets `err_flag`, and assembly and storing carry on as normal.
- R12: `ch_ready` is low while disconnected, between records, during an outstanding store and while an end of record is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_int_en | input | 1 | Processor interrupt enable (level) |
| start | input | 1 | Connect pulse; loads setup |
| cfg_width | input | 2 | 00 = 6-bit, 01 = 12-bit, 1x = 24-bit |
| cfg_cpw | input | 2 | Characters per word minus one |
| cfg_func | input | 3 | Function: 0xx compatible, 100 record-disconnect, 101 record-proceed, 110 signal-disconnect, 111 signal-proceed |
| cfg_ilce | input | 1 | Memory interlace enable |
| cfg_scan | input | 1 | Scan mode |
| cfg_zwc_ie | input | 1 | Zero-word-count interrupt enable |
| cfg_eor_ie | input | 1 | End-of-record interrupt enable |
| cfg_addr | input | ADDR_W | Start memory address |
| cfg_wc | input | WC_W | Start word count |
| ch_valid | input | 1 | Character valid |
| ch_ready | output | 1 | Character can be accepted |
| ch_data | input | 4*CHAR_W | Character, right-aligned |
| ch_err | input | 1 | Device error on this character |
| eor_in | input | 1 | End-of-record pulse from device |
| mem_req | output | 1 | One-cycle memory write strobe |
| mem_ack | input | 1 | Memory write acknowledge |
| mem_addr | output | ADDR_W | Current memory address |
| mem_data | output | 4*CHAR_W | Word to store |
| word_out | output | 4*CHAR_W | Assembly register |
| word_full | output | 1 | Assembly register holds a full word |
| word_count | output | WC_W | Remaining word count |
| connected | output | 1 | Channel connected |
| inter_rec | output | 1 | Between records |
| err_flag | output | 1 | Overrun or device error seen |
| irq_eow | output | 1 | End-of-word interrupt pulse |
| irq_zwc | output | 1 | Zero-word-count interrupt pulse |
| irq_eor | output | 1 | End-of-record interrupt pulse |
| disc | output | 1 | Disconnect pulse |

## Verification
A wrong character counter shows up within one accepted character. Either `mem_req` fires early or late, or `mem_data` appears with its characters in the wrong positions, because the expected word is fixed by the width and count. A wrong address or word-count step appears at `mem_addr` or `word_count` in the cycle after `mem_ack`. A mistaken function decode shows up at the end of a transfer: a missing or extra `irq_zwc`, `irq_eor` or `disc` pulse in the cycle after the final acknowledge or end-of-record, or `inter_rec` against `connected` in the wrong combination. Padding mistakes are visible on the `mem_data` of the single store that follows an end of record.

// File: rtl/chwp_pkg.sv
package chwp_pkg;

  typedef enum logic [1:0] {
    WID6  = 2'b00,
    WID12 = 2'b01,
    WID24 = 2'b10
  } width_e;

  // function code bit positions
  localparam int FN_EXT = 2;
  localparam int FN_SIG = 1;
  localparam int FN_PRO = 0;

  function automatic width_e decode_width(input logic [1:0] code);
    if (code[1])      return WID24;
    else if (code[0]) return WID12;
    else              return WID6;
  endfunction

endpackage

// File: rtl/chwp_pack.sv
module chwp_pack
  import chwp_pkg::*;
#(
  parameter int CHAR_W = 6
) (
  input  width_e                  width,
  input  logic [4*CHAR_W-1:0]     cur,
  input  logic [4*CHAR_W-1:0]     chr,
  input  logic [2:0]              cnt,
  input  logic [1:0]              cpw,
  output logic [4*CHAR_W-1:0]     packed_w,
  output logic [4*CHAR_W-1:0]     padded_w
);
  localparam int WORD_W = 4 * CHAR_W;
  localparam int HALF_W = 2 * CHAR_W;

  logic [2:0] cpw_ext;
  logic [2:0] miss;

  assign cpw_ext = {1'b0, cpw};
  assign miss    = (cnt <= cpw_ext) ? (cpw_ext + 3'd1 - cnt) : 3'd0;

  always_comb begin
    case (width)
      WID6:    packed_w = {cur[WORD_W-CHAR_W-1:0], chr[CHAR_W-1:0]};
      WID12:   packed_w = {cur[WORD_W-HALF_W-1:0], chr[HALF_W-1:0]};
      default: packed_w = chr;
    endcase
  end

  always_comb begin
    case (width)
      WID6: begin
        case (miss)
          3'd0:    padded_w = cur;
          3'd1:    padded_w = {cur[WORD_W-CHAR_W-1:0], {CHAR_W{1'b0}}};
          3'd2:    padded_w = {cur[WORD_W-2*CHAR_W-1:0], {2*CHAR_W{1'b0}}};
          3'd3:    padded_w = {cur[WORD_W-3*CHAR_W-1:0], {3*CHAR_W{1'b0}}};
          default: padded_w = '0;
        endcase
      end
      WID12:   padded_w = (miss != 3'd0) ? {cur[WORD_W-HALF_W-1:0], {HALF_W{1'b0}}} : cur;
      default: padded_w = (miss != 3'd0) ? '0 : cur;
    endcase
  end

endmodule

// File: rtl/chwp_xfer_ctr.sv
module chwp_xfer_ctr #(
  parameter int ADDR_W = 14,
  parameter int WC_W   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WC_W-1:0]   load_wc,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [WC_W-1:0]   wc,
  output logic              last
);
  localparam logic [WC_W-1:0] WC_ONE = WC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      wc   <= '0;
    end else if (load) begin
      addr <= load_addr;
      wc   <= load_wc;
    end else if (step) begin
      addr <= addr + ADDR_W'(1);
      wc   <= wc - WC_ONE;
    end
  end

  assign last = (wc == WC_ONE);

  AST_WC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> wc == $past(wc) - WC_ONE); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> addr == $past(addr) + ADDR_W'(1)); // R5

endmodule

// File: rtl/chan_word_packer.sv
module chan_word_packer
  import chwp_pkg::*;
#(
  parameter int CHAR_W = 6,
  parameter int ADDR_W = 14,
  parameter int WC_W   = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_int_en,
  input  logic                start,
  input  logic [1:0]          cfg_width,
  input  logic [1:0]          cfg_cpw,
  input  logic [2:0]          cfg_func,
  input  logic                cfg_ilce,
  input  logic                cfg_scan,
  input  logic                cfg_zwc_ie,
  input  logic                cfg_eor_ie,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [WC_W-1:0]     cfg_wc,
  input  logic                ch_valid,
  output logic                ch_ready,
  input  logic [4*CHAR_W-1:0] ch_data,
  input  logic                ch_err,
  input  logic                eor_in,
  output logic                mem_req,
  input  logic                mem_ack,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [4*CHAR_W-1:0] mem_data,
  output logic [4*CHAR_W-1:0] word_out,
  output logic                word_full,
  output logic [WC_W-1:0]     word_count,
  output logic                connected,
  output logic                inter_rec,
  output logic                err_flag,
  output logic                irq_eow,
  output logic                irq_zwc,
  output logic                irq_eor,
  output logic                disc
);
  localparam int WORD_W = 4 * CHAR_W;

  // channel state
  logic              conn_q, irec_q, ilce_q, err_q, scan_q;
  logic              zwc_ie_q, eor_ie_q;
  logic [2:0]        func_q;
  width_e            width_q;
  logic [1:0]        cpw_q;
  logic [2:0]        cnt_q;
  logic [WORD_W-1:0] war_q;
  logic              pend_q, pend_eor_q, eor_req_q;
  logic              mem_req_q, irq_eow_q, irq_zwc_q, irq_eor_q, disc_q;

  // derived
  logic              is_ext, is_sig, is_pro;
  logic [2:0]        cpw_ext, cpw_one, cnt_inc;
  logic              start_ok, accept, full_n;
  logic              ack_done, eor_go, eor_store, finish, zwc_hit, needs_pad;
  logic              wc_last;
  logic [1:0]        cpw_load;
  width_e            width_load;
  logic [WORD_W-1:0] packed_w, padded_w;

  assign is_ext  = func_q[FN_EXT];
  assign is_sig  = func_q[FN_SIG];
  assign is_pro  = func_q[FN_PRO];
  assign cpw_ext = {1'b0, cpw_q};
  assign cpw_one = cpw_ext + 3'd1;

  assign start_ok = start && !conn_q;
  assign ch_ready = conn_q && !irec_q && !pend_q && !eor_req_q;
  assign accept   = ch_valid && ch_ready;

  // counter after this character: pinned in scan, saturating at full
  assign cnt_inc = scan_q ? cpw_ext :
                   (cnt_q > cpw_ext) ? cnt_q : (cnt_q + 3'd1);
  assign full_n  = cnt_inc > cpw_ext;

  assign ack_done  = pend_q && mem_ack;
  assign eor_go    = conn_q && eor_req_q && !pend_q;
  assign eor_store = eor_go && is_ext && (cnt_q != 3'd0) && ilce_q;
  assign needs_pad = !is_ext || (cnt_q != 3'd0);
  assign finish    = (ack_done && pend_eor_q) || (eor_go && !eor_store);
  assign zwc_hit   = ack_done && !pend_eor_q && wc_last;

  assign width_load = decode_width(cfg_width);
  always_comb begin
    case (width_load)
      WID6:    cpw_load = cfg_cpw;
      WID12:   cpw_load = {1'b0, cfg_cpw[0]};
      default: cpw_load = 2'b00;
    endcase
  end

  chwp_pack #(.CHAR_W(CHAR_W)) u_pack (
    .width    (width_q),
    .cur      (war_q),
    .chr      (ch_data),
    .cnt      (cnt_q),
    .cpw      (cpw_q),
    .packed_w (packed_w),
    .padded_w (padded_w)
  );

  chwp_xfer_ctr #(.ADDR_W(ADDR_W), .WC_W(WC_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .load_addr (cfg_addr),
    .load_wc   (cfg_wc),
    .step      (ack_done),
    .addr      (mem_addr),
    .wc        (word_count),
    .last      (wc_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q     <= 1'b0;
      irec_q     <= 1'b0;
      ilce_q     <= 1'b0;
      err_q      <= 1'b0;
      scan_q     <= 1'b0;
      zwc_ie_q   <= 1'b0;
      eor_ie_q   <= 1'b0;
      func_q     <= 3'd0;
      width_q    <= WID6;
      cpw_q      <= 2'd0;
      cnt_q      <= 3'd0;
      war_q      <= '0;
      pend_q     <= 1'b0;
      pend_eor_q <= 1'b0;
      eor_req_q  <= 1'b0;
      mem_req_q  <= 1'b0;
      irq_eow_q  <= 1'b0;
      irq_zwc_q  <= 1'b0;
      irq_eor_q  <= 1'b0;
      disc_q     <= 1'b0;
    end else begin
      mem_req_q <= 1'b0;
      irq_eow_q <= 1'b0;
      irq_zwc_q <= 1'b0;
      irq_eor_q <= 1'b0;
      disc_q    <= 1'b0;
      if (start_ok) begin
        conn_q     <= 1'b1;
        irec_q     <= 1'b0;
        ilce_q     <= cfg_ilce;
        err_q      <= 1'b0;
        scan_q     <= cfg_scan;
        zwc_ie_q   <= cfg_zwc_ie;
        eor_ie_q   <= cfg_eor_ie;
        func_q     <= cfg_func;
        width_q    <= width_load;
        cpw_q      <= cpw_load;
        cnt_q      <= 3'd0;
        war_q      <= '0;
        pend_q     <= 1'b0;
        pend_eor_q <= 1'b0;
        eor_req_q  <= 1'b0;
      end else if (conn_q) begin
        if (accept) begin
          war_q <= packed_w;
          if (ch_err) err_q <= 1'b1;
          if (full_n) begin
            if (ilce_q) begin
              cnt_q     <= cnt_inc;
              pend_q    <= 1'b1;
              mem_req_q <= 1'b1;
            end else if (!is_ext) begin
              cnt_q <= cnt_inc;
              if (cpu_int_en) irq_eow_q <= 1'b1;
            end else if (is_sig) begin
              cnt_q <= cnt_inc;
              err_q <= 1'b1;
            end else begin
              cnt_q <= cpw_ext;
            end
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        if (eor_in && !irec_q) eor_req_q <= 1'b1;
        if (ack_done) begin
          pend_q     <= 1'b0;
          pend_eor_q <= 1'b0;
          war_q      <= '0;
          cnt_q      <= 3'd0;
        end
        if (zwc_hit) begin
          ilce_q <= 1'b0;
          if (is_ext && zwc_ie_q) irq_zwc_q <= 1'b1;
          if (is_ext && is_sig && !is_pro) begin
            if (eor_ie_q) irq_eor_q <= 1'b1;
            conn_q    <= 1'b0;
            disc_q    <= 1'b1;
            eor_req_q <= 1'b0;
          end
        end
        if (eor_go) begin
          eor_req_q <= 1'b0;
          war_q     <= padded_w;
          if (needs_pad) cnt_q <= cpw_one;
          if (eor_store) begin
            pend_q     <= 1'b1;
            pend_eor_q <= 1'b1;
            mem_req_q  <= 1'b1;
          end
        end
        if (finish) begin
          ilce_q    <= 1'b0;
          eor_req_q <= 1'b0;
          if (eor_ie_q || (!is_ext && cpu_int_en)) irq_eor_q <= 1'b1;
          if (is_ext && is_pro) irec_q <= 1'b1;
          else begin
            conn_q <= 1'b0;
            disc_q <= 1'b1;
          end
        end
      end
    end
  end

  assign mem_req   = mem_req_q;
  assign mem_data  = war_q;
  assign word_out  = war_q;
  assign word_full = cnt_q > cpw_ext;
  assign connected = conn_q;
  assign inter_rec = irec_q;
  assign err_flag  = err_q;
  assign irq_eow   = irq_eow_q;
  assign irq_zwc   = irq_zwc_q;
  assign irq_eor   = irq_eor_q;
  assign disc      = disc_q;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R5

  AST_STALL_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> !ch_ready); // R12

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !mem_ack && !start |=> $stable(mem_addr)); // R5

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    conn_q |-> cnt_q <= cpw_one); // R3

  AST_SCAN_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    conn_q && scan_q && !eor_req_q && !pend_q |=> !mem_req); // R10

  AST_DISC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    disc |-> !connected); // R6

  AST_IREC_CONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
    inter_rec |-> connected && !ch_ready); // R9

endmodule

// File: tb/tb_chan_word_packer.sv
module tb_chan_word_packer;
  localparam int CHAR_W = 6;
  localparam int ADDR_W = 14;
  localparam int WC_W   = 15;
  localparam int WORD_W = 4 * CHAR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_int_en = 1'b0;
  logic start = 1'b0;
  logic [1:0] cfg_width = 2'b00;
  logic [1:0] cfg_cpw = 2'b00;
  logic [2:0] cfg_func = 3'b000;
  logic cfg_ilce = 1'b0, cfg_scan = 1'b0, cfg_zwc_ie = 1'b0, cfg_eor_ie = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [WC_W-1:0] cfg_wc = '0;
  logic ch_valid = 1'b0;
  logic ch_ready;
  logic [WORD_W-1:0] ch_data = '0;
  logic ch_err = 1'b0;
  logic eor_in = 1'b0;
  logic mem_req;
  logic mem_ack = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_data, word_out;
  logic word_full;
  logic [WC_W-1:0] word_count;
  logic connected, inter_rec, err_flag, irq_eow, irq_zwc, irq_eor, disc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chan_word_packer #(.CHAR_W(CHAR_W), .ADDR_W(ADDR_W), .WC_W(WC_W)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_int_en(cpu_int_en), .start(start),
    .cfg_width(cfg_width), .cfg_cpw(cfg_cpw), .cfg_func(cfg_func),
    .cfg_ilce(cfg_ilce), .cfg_scan(cfg_scan), .cfg_zwc_ie(cfg_zwc_ie),
    .cfg_eor_ie(cfg_eor_ie), .cfg_addr(cfg_addr), .cfg_wc(cfg_wc),
    .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_data(ch_data), .ch_err(ch_err),
    .eor_in(eor_in), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_data(mem_data), .word_out(word_out), .word_full(word_full),
    .word_count(word_count), .connected(connected), .inter_rec(inter_rec),
    .err_flag(err_flag), .irq_eow(irq_eow), .irq_zwc(irq_zwc),
    .irq_eor(irq_eor), .disc(disc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ch_valid = 1'b0; eor_in = 1'b0; mem_ack = 1'b0; start = 1'b0; ch_err = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic connect(input logic [1:0] w, input logic [1:0] cpw, input logic [2:0] fn,
                         input logic ilce, input logic scan, input logic zie, input logic eie,
                         input logic [ADDR_W-1:0] a, input logic [WC_W-1:0] wc);
    cfg_width = w; cfg_cpw = cpw; cfg_func = fn; cfg_ilce = ilce; cfg_scan = scan;
    cfg_zwc_ie = zie; cfg_eor_ie = eie; cfg_addr = a; cfg_wc = wc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input logic [WORD_W-1:0] d, input logic e);
    ch_valid = 1'b1; ch_data = d; ch_err = e;
    while (!ch_ready) @(negedge clk);
    @(negedge clk);
    ch_valid = 1'b0; ch_err = 1'b0;
  endtask

  task automatic ack();
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
  endtask

  task automatic end_record();
    eor_in = 1'b1;
    @(negedge clk);
    eor_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 connected", connected, 0);
    chk("R1 ready", ch_ready, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 flags", {inter_rec, err_flag, word_full, irq_eow, irq_zwc, irq_eor, disc}, 0);
    chk("R12 ready low disconnected", ch_ready, 0);
  endtask

  task automatic t_pack6();
    do_reset();
    connect(2'b00, 2'd2, 3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 14'h100, 15'd5);
    send(24'h11, 1'b0);
    send(24'h22, 1'b0);
    chk("R3 not full after two", {word_full, mem_req}, 0);
    send(24'h33, 1'b0);
    chk("R5 mem_req", mem_req, 1);
    chk("R3 packed word", mem_data, 24'h0118B3);
    chk("R5 mem_addr", mem_addr, 14'h100);
    chk("R12 ready low while store pending", ch_ready, 0);
    @(negedge clk);
    chk("R5 strobe single cycle", mem_req, 0);
    chk("R12 still stalled without ack", ch_ready, 0);
    ack();
    chk("R5 addr step", mem_addr, 14'h101);
    chk("R5 count step", word_count, 15'd4);
    chk("R5 register cleared", word_out, 0);
    chk("R12 ready after ack", ch_ready, 1);
    connect(2'b10, 2'd0, 3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 14'h3000, 15'd77);
    chk("R2 start ignored addr", mem_addr, 14'h101);
    chk("R2 start ignored count", word_count, 15'd4);
  endtask

  task automatic t_w12();
    do_reset();
    connect(2'b01, 2'd3, 3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 14'h20, 15'd2);
    send(24'h5AFABC, 1'b0);
    chk("R4 12-bit one char not full", mem_req, 0);
    send(24'h000123, 1'b0);
    chk("R4 12-bit word", mem_data, 24'hABC123);
    chk("R4 12-bit store", mem_req, 1);
    ack();
  endtask

  task automatic t_zwc();
    do_reset();
    connect(2'b11, 2'd3, 3'b110, 1'b1, 1'b0, 1'b1, 1'b1, 14'h40, 15'd1);
    send(24'h123456, 1'b0);
    chk("R4 24-bit replace", mem_data, 24'h123456);
    chk("R4 24-bit one per word", mem_req, 1);
    ack();
    chk("R6 zwc irq", irq_zwc, 1);
    chk("R6 eor irq", irq_eor, 1);
    chk("R6 disc", disc, 1);
    chk("R6 disconnected", connected, 0);
  endtask

  task automatic t_wrap();
    do_reset();
    connect(2'b10, 2'd0, 3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 14'h10, 15'd0);
    send(24'hABCDEF, 1'b1);
    chk("R11 err with store", {err_flag, mem_req}, 2'b11);
    ack();
    chk("R5 count wraps", word_count, 15'h7FFF);
    chk("R6 no zwc on wrap", irq_zwc, 0);
    chk("R11 assembly continues", ch_ready, 1);
  endtask

  task automatic t_eor_pad();
    do_reset();
    connect(2'b00, 2'd3, 3'b101, 1'b1, 1'b0, 1'b0, 1'b1, 14'h200, 15'd9);
    send(24'h3F, 1'b0);
    send(24'h01, 1'b0);
    end_record();
    chk("R8 pad store", mem_req, 1);
    chk("R8 padded word", mem_data, 24'hFC1000);
    ack();
    chk("R9 eor irq", irq_eor, 1);
    chk("R9 inter-record", {inter_rec, connected, ch_ready}, 3'b110);
    chk("R9 no disc on proceed", disc, 0);
  endtask

  task automatic t_compat();
    do_reset();
    cpu_int_en = 1'b1;
    connect(2'b00, 2'd0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0, 15'd3);
    send(24'h15, 1'b0);
    chk("R7 compat eow", irq_eow, 1);
    chk("R7 compat word", {word_full, word_out}, {1'b1, 24'h000015});
    end_record();
    chk("R9 compat eor irq", irq_eor, 1);
    chk("R9 compat disc", {disc, connected}, 2'b10);
    chk("R8 compat no store", mem_req, 0);
    cpu_int_en = 1'b0;
  endtask

  task automatic t_signal();
    do_reset();
    connect(2'b00, 2'd0, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0, 15'd3);
    send(24'h2A, 1'b0);
    chk("R7 signal overrun", {err_flag, word_full}, 2'b11);
  endtask

  task automatic t_record_hold();
    do_reset();
    connect(2'b00, 2'd0, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0, 15'd3);
    send(24'h05, 1'b0);
    chk("R7 record hold not full", {word_full, err_flag}, 0);
    send(24'h06, 1'b0);
    chk("R7 record shifts on", word_out, 24'h000146);
  endtask

  task automatic t_scan();
    do_reset();
    connect(2'b00, 2'd0, 3'b100, 1'b1, 1'b1, 1'b0, 1'b0, 14'h0, 15'd3);
    send(24'h01, 1'b0);
    send(24'h02, 1'b0);
    send(24'h03, 1'b0);
    send(24'h04, 1'b0);
    chk("R10 scan no store", {mem_req, word_full}, 0);
    chk("R10 scan word", word_out, 24'h0420C4);
    chk("R10 count untouched", word_count, 15'd3);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_pack6();
    t_w12();
    t_zwc();
    t_wrap();
    t_eor_pad();
    t_compat();
    t_signal();
    t_record_hold();
    t_scan();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule